// File: doc/BRIEF.md
# Boundary Scan Test Port with Debug Probe Selector

This block is the serial test port of a programmable device. It runs the sixteen-state test controller from a test clock and a mode-select line. A three-bit instruction register picks one of three data paths between the serial input and the serial output. The paths are a one-bit pass-through, a boundary cell chain of `BSR_LEN` bits, and a private `PROBE_W`-bit selector that chooses which internal node is routed out for debug observation.

The boundary chain and the probe selector each have a shift stage and a separate output latch. Board test and debug software can therefore shift new values in without disturbing what the device is driving or observing. A configuration input switches the whole port off. While it is off, the controller rests in its reset state, the serial output is not driven, and the three input pins are flagged as free for ordinary user I/O. There is no test-reset pin. Only the power-on reset input or holding the mode line high returns the controller to reset.

Top module: `jtag_tap_probe`

## Requirements
- R1: The controller steps on each rising `tck` edge according to the standard test-port state diagram. `tap_state` reports the state in the standard 4-bit encoding: reset F, idle C, select-DR 7, capture-DR 6, shift-DR 2, exit1-DR 1, pause-DR 3, exit2-DR 0, update-DR 5, select-IR 4, capture-IR E, shift-IR A, exit1-IR 9, pause-IR B, exit2-IR 8, update-IR D.
- R2: Five consecutive rising edges with `tms` high bring the controller to the reset state from any state. Entering or staying in the reset state makes BYPASS the current instruction.
- R3: While `por_n` is low, the controller is held in the reset state asynchronously. The instruction is BYPASS, both output latches are zero, and `tdo_oe` is low.
- R4: While `tap_en` is 0, the controller stays in the reset state whatever `tms` does, `tdo_oe` is low, and `user_io_free` is 1. While `tap_en` is 1, `user_io_free` is 0.
- R5: `tdo_oe` is high only while the controller is in shift-IR or shift-DR. `tdo` changes only on falling `tck` edges.
- R6: The instruction register is 3 bits wide. Capture-IR loads 3'b001. Shift-IR moves `tdi` in at the MSB and bit 0 out first. Update-IR makes the shifted value the current instruction.
- R7: Instruction codes: 3'b000 boundary drive (`extest_mode` high), 3'b001 boundary sample/preload, 3'b011 probe select, 3'b111 bypass. Every other code selects the bypass register.
- R8: The bypass register is one bit long and captures 0 in capture-DR.
- R9: Under codes 000 and 001, the boundary register is `BSR_LEN` bits long. It captures `bsr_capture` in capture-DR, shifts bit 0 out first, and takes `tdi` in at the MSB.
- R10: Under code 011, the probe register is `PROBE_W` bits long. It captures the current `probe_sel` value in capture-DR and shifts like the boundary register.
- R11: `bsr_update` and `probe_sel` change only on the rising edge that leaves update-DR, and only when their own register is selected. They hold steady while shifting is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tap_en | input | 1 | Configuration enable of the test port |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| user_io_free | output | 1 | High when the test pins are released to user I/O |
| bsr_capture | input | BSR_LEN | Parallel values captured into the boundary chain |
| bsr_update | output | BSR_LEN | Boundary output latch |
| probe_sel | output | PROBE_W | Probe node selection latch |
| extest_mode | output | 1 | High while the boundary drive instruction is current |
| tap_state | output | 4 | Current controller state |

## Verification
The bench builds the port with `BSR_LEN` = 10 and `PROBE_W` = 4. These widths differ from each other, from the instruction width and from the bypass length. A wrong length on any path therefore shows up as a shifted bit position in the returned stream. Both widths are short enough that each scan pushes a few extra bits past the register end, so the bench reads the captured word, the bits that fall through and the latched result within one pass.

// File: rtl/jtag_tap_probe.sv
module jtag_tap_probe #(
  parameter int BSR_LEN = 8,
  parameter int PROBE_W = 6
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tap_en,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               user_io_free,
  input  logic [BSR_LEN-1:0] bsr_capture,
  output logic [BSR_LEN-1:0] bsr_update,
  output logic [PROBE_W-1:0] probe_sel,
  output logic               extest_mode,
  output logic [3:0]         tap_state
);

  localparam logic [3:0] S_TLR = 4'hF, S_RTI = 4'hC, S_SDR = 4'h7, S_CDR = 4'h6,
                         S_SHD = 4'h2, S_E1D = 4'h1, S_PD  = 4'h3, S_E2D = 4'h0,
                         S_UDR = 4'h5, S_SIR = 4'h4, S_CIR = 4'hE, S_SHI = 4'hA,
                         S_E1I = 4'h9, S_PI  = 4'hB, S_E2I = 4'h8, S_UIR = 4'hD;
  localparam logic [2:0] I_EXT = 3'b000, I_SMP = 3'b001, I_PRB = 3'b011, I_BYP = 3'b111;

  logic [3:0]         st, nxt;
  logic [2:0]         ir, ir_sh;
  logic               byp;
  logic [BSR_LEN-1:0] bsr_sh;
  logic [PROBE_W-1:0] prb_sh;
  logic               sel_bsr, sel_prb, tdo_d;

  assign tap_state    = st;
  assign user_io_free = ~tap_en;
  assign sel_bsr      = (ir == I_EXT) || (ir == I_SMP);
  assign sel_prb      = (ir == I_PRB);
  assign extest_mode  = (ir == I_EXT);

  always_comb begin
    case (st)
      S_TLR:   nxt = tms ? S_TLR : S_RTI;
      S_RTI:   nxt = tms ? S_SDR : S_RTI;
      S_SDR:   nxt = tms ? S_SIR : S_CDR;
      S_CDR:   nxt = tms ? S_E1D : S_SHD;
      S_SHD:   nxt = tms ? S_E1D : S_SHD;
      S_E1D:   nxt = tms ? S_UDR : S_PD;
      S_PD:    nxt = tms ? S_E2D : S_PD;
      S_E2D:   nxt = tms ? S_UDR : S_SHD;
      S_UDR:   nxt = tms ? S_SDR : S_RTI;
      S_SIR:   nxt = tms ? S_TLR : S_CIR;
      S_CIR:   nxt = tms ? S_E1I : S_SHI;
      S_SHI:   nxt = tms ? S_E1I : S_SHI;
      S_E1I:   nxt = tms ? S_UIR : S_PI;
      S_PI:    nxt = tms ? S_E2I : S_PI;
      S_E2I:   nxt = tms ? S_UIR : S_SHI;
      default: nxt = tms ? S_SDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)       st <= S_TLR;
    else if (!tap_en) st <= S_TLR;
    else              st <= nxt;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      ir    <= I_BYP;
      ir_sh <= 3'b001;
    end else if (!tap_en || st == S_TLR) begin
      ir    <= I_BYP;
    end else begin
      case (st)
        S_CIR:   ir_sh <= 3'b001;
        S_SHI:   ir_sh <= {tdi, ir_sh[2:1]};
        S_UIR:   ir    <= ir_sh;
        default: ;
      endcase
    end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      byp        <= 1'b0;
      bsr_sh     <= '0;
      prb_sh     <= '0;
      bsr_update <= '0;
      probe_sel  <= '0;
    end else if (tap_en) begin
      case (st)
        S_CDR: begin
          byp <= 1'b0;
          if (sel_bsr) bsr_sh <= bsr_capture;
          if (sel_prb) prb_sh <= probe_sel;
        end
        S_SHD: begin
          byp <= tdi;
          if (sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
          if (sel_prb) prb_sh <= {tdi, prb_sh[PROBE_W-1:1]};
        end
        S_UDR: begin
          if (sel_bsr) bsr_update <= bsr_sh;
          if (sel_prb) probe_sel  <= prb_sh;
        end
        default: ;
      endcase
    end

  assign tdo_d = (st == S_SHI) ? ir_sh[0] :
                 sel_bsr       ? bsr_sh[0] :
                 sel_prb       ? prb_sh[0] : byp;

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= tap_en && (st == S_SHI || st == S_SHD);
    end

  assert_tlr_after_five_R2: assert property (@(posedge tck) disable iff (!por_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> st == S_TLR);

  assert_disabled_idle_R4: assert property (@(posedge tck) disable iff (!por_n)
    !tap_en |=> (st == S_TLR && ir == I_BYP));

  assert_oe_in_shift_R5: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (st == S_SHI || st == S_SHD));

  assert_ir_capture_R6: assert property (@(posedge tck) disable iff (!por_n)
    (tap_en && st == S_CIR) |=> ir_sh == 3'b001);

  assert_bypass_capture_R8: assert property (@(posedge tck) disable iff (!por_n)
    (tap_en && st == S_CDR) |=> !byp);

  assert_bsr_latch_hold_R11: assert property (@(posedge tck) disable iff (!por_n)
    (st != S_UDR) |=> $stable(bsr_update));

  assert_probe_latch_hold_R11: assert property (@(posedge tck) disable iff (!por_n)
    (st != S_UDR || !sel_prb) |=> $stable(probe_sel));

endmodule

// File: tb/jtag_tap_probe_test.sv
`timescale 1ns/1ps
module jtag_tap_probe_test;
  localparam int BL = 10;
  localparam int PW = 4;

  logic tck = 0, por_n = 0, tap_en = 1, tms = 1, tdi = 0;
  logic tdo, tdo_oe, user_io_free, extest_mode;
  logic [BL-1:0] bsr_capture = '0, bsr_update;
  logic [PW-1:0] probe_sel;
  logic [3:0] tap_state;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  jtag_tap_probe #(.BSR_LEN(BL), .PROBE_W(PW)) uut (
    .tck(tck), .por_n(por_n), .tap_en(tap_en), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .user_io_free(user_io_free),
    .bsr_capture(bsr_capture), .bsr_update(bsr_update), .probe_sel(probe_sel),
    .extest_mode(extest_mode), .tap_state(tap_state));

  always #2.5 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d, output logic o);
    o = tdo; tms = t; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic mv(input logic t);
    logic o;
    tick(t, 1'b0, o);
  endtask

  task automatic scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      logic o;
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic [63:0] o;
    mv(1); mv(1); mv(0); mv(0);
    scan(3, {61'b0, code}, o);
    cap = o[2:0];
    mv(1); mv(0);
  endtask

  task automatic to_shift_dr();
    mv(1); mv(0); mv(0);
  endtask

  task automatic t_reset();
    chk("R3 state", tap_state, 4'hF);
    chk("R3 oe", tdo_oe, 0);
    chk("R3 probe", probe_sel, 0);
    chk("R3 bsr", bsr_update, 0);
  endtask

  task automatic t_walk();
    int tv[44] = '{0,1,0,0,1,0,1,0,1,1,1,1,0,0,1,0,1,0,1,1,0,1,1,1,
                   0,1,0,1,0,0,1,1,1,1,0,1,0,0,1,1,1,1,1,1};
    int ev[44] = '{12,7,6,2,1,3,0,2,1,5,7,4,14,10,9,11,8,10,9,13,12,7,4,15,
                   12,7,6,1,3,3,0,5,7,4,14,9,11,11,8,13,7,4,15,15};
    for (int i = 0; i < 44; i++) begin
      mv(tv[i][0]);
      chk($sformatf("R1 step %0d", i), tap_state, ev[i]);
    end
  endtask

  task automatic t_ir();
    logic [2:0] c;
    mv(0);
    load_ir(3'b111, c);
    chk("R6 capture", c, 3'b001);
    chk("R1 idle", tap_state, 4'hC);
  endtask

  task automatic bypass_scan(input string req);
    logic [63:0] o, d;
    d = 64'hB5;
    to_shift_dr();
    scan(8, d, o);
    mv(1); mv(0);
    chk(req, o[7:0], {d[6:0], 1'b0});
  endtask

  task automatic t_bypass();
    logic [2:0] c;
    bypass_scan("R8 bypass length");
    load_ir(3'b101, c);
    bypass_scan("R7 unused code bypass");
    load_ir(3'b111, c);
  endtask

  task automatic t_oe();
    logic o;
    chk("R5 oe idle", tdo_oe, 0);
    to_shift_dr();
    chk("R5 oe shift", tdo_oe, 1);
    chk("R5 tdo captured", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R5 tdo holds at rise", tdo, 0);
    @(negedge tck); #1;
    chk("R5 tdo at fall", tdo, 1);
    tick(1, 0, o);
    chk("R5 oe exit", tdo_oe, 0);
    mv(1); mv(0);
  endtask

  task automatic t_sample();
    logic [2:0] c;
    logic [63:0] o, d, e;
    bsr_capture = 10'h2C7;
    load_ir(3'b001, c);
    chk("R7 sample not drive", extest_mode, 0);
    d = 64'h3A5B;
    to_shift_dr();
    scan(BL + 4, d, o);
    e = {50'b0, d[3:0], bsr_capture};
    chk("R9 capture and length", o[BL+3:0], e[BL+3:0]);
    chk("R11 hold while shifting", bsr_update, 0);
    mv(1);
    chk("R11 hold in update", bsr_update, 0);
    mv(0);
    chk("R9 update", bsr_update, d[BL+3:4]);
  endtask

  task automatic t_extest();
    logic [2:0] c;
    load_ir(3'b000, c);
    chk("R7 drive mode", extest_mode, 1);
    load_ir(3'b111, c);
    chk("R7 drive off", extest_mode, 0);
  endtask

  task automatic t_probe();
    logic [2:0] c;
    logic [63:0] o;
    load_ir(3'b011, c);
    to_shift_dr();
    scan(PW + 3, 64'h5D, o);
    chk("R10 capture and length", o[PW+2:0], {3'b101, 4'h0});
    mv(1); mv(0);
    chk("R10 update", probe_sel, 4'hB);
    to_shift_dr();
    scan(PW, 64'h6, o);
    chk("R10 recapture", o[PW-1:0], 4'hB);
    mv(1); mv(0);
    chk("R10 second update", probe_sel, 4'h6);
    load_ir(3'b111, c);
    to_shift_dr();
    scan(PW, 64'h9, o);
    mv(1); mv(0);
    chk("R11 probe ignores bypass update", probe_sel, 4'h6);
  endtask

  task automatic t_five();
    logic [2:0] c;
    load_ir(3'b011, c);
    to_shift_dr();
    for (int i = 0; i < 5; i++) mv(1);
    chk("R2 reset state", tap_state, 4'hF);
    mv(0);
    bypass_scan("R2 bypass after reset");
  endtask

  task automatic t_disable();
    chk("R4 enabled pins", user_io_free, 0);
    tap_en = 0;
    mv(0); mv(0); mv(1); mv(0);
    chk("R4 state held", tap_state, 4'hF);
    chk("R4 oe", tdo_oe, 0);
    chk("R4 pins free", user_io_free, 1);
    tap_en = 1;
    mv(0);
    chk("R4 resumes", tap_state, 4'hC);
  endtask

  task automatic t_por();
    logic [2:0] c;
    logic [63:0] o;
    load_ir(3'b011, c);
    to_shift_dr();
    scan(PW, 64'hA, o);
    mv(1); mv(0);
    chk("R3 probe loaded", probe_sel, 4'hA);
    to_shift_dr();
    por_n = 0; #1;
    chk("R3 async state", tap_state, 4'hF);
    chk("R3 async probe", probe_sel, 0);
    chk("R3 async bsr", bsr_update, 0);
    @(negedge tck); #1;
    chk("R3 async oe", tdo_oe, 0);
    por_n = 1;
    mv(0);
    bypass_scan("R3 bypass after por");
  endtask

  initial begin
    repeat (3) @(negedge tck);
    #1;
    t_reset();
    por_n = 1;
    t_walk();
    t_ir();
    t_bypass();
    t_oe();
    t_sample();
    t_extest();
    t_probe();
    t_five();
    t_disable();
    t_por();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule